// File: doc/BRIEF.md
# Banked ROM/RAM Window Mapper

This block sits on an 8-bit host slot card. It maps a 2 KB expansion address window onto two larger banked stores. Window offsets below 0x400 reach one 1 KB page of an 8 KB static RAM. Offsets from 0x400 upward reach one 1 KB page of a 32 KB firmware ROM.

Two bank-select registers choose the pages. The host writes them through the card's 16-byte I/O register space. The ROM-bank register reads back with a fixed device ID packed into its upper three bits. A further register reports the position of a physical DMA-enable switch.

The SRAM is external and synchronous. The mapper turns a window access into an SRAM strobe and address, or into a read of the internal ROM. The ROM is modelled as a synchronous port whose contents are computed from a parameter, so no image file is needed. Window reads return data one cycle after the request, together with a valid strobe.

Top module: `bankwin_mapper`

## Requirements
- R1: An I/O write to register offset 0xE loads the ROM bank from the low 5 bits of the written byte. The upper bits are dropped, giving 32 pages of 1 KB.
- R2: An I/O write to register offset 0xF loads the RAM bank from the low 3 bits of the written byte, giving 8 pages of 1 KB.
- R3: A window read or write at an offset below 0x400 drives `sram_addr` = RAM bank × 0x400 + offset. A read raises `sram_re`. A write raises `sram_we` and presents the write data on `sram_wdata`. `win_rd` and `win_wr` are never high together.
- R4: A window read at an offset of 0x400 or above returns the ROM byte at linear address A = ROM bank × 0x400 + (offset − 0x400). The default image holds A[7:0] XOR (bank shifted left by 3) XOR 0x5A.
- R5: A window write at an offset of 0x400 or above raises no SRAM strobe. It changes neither the SRAM nor the ROM.
- R6: Reading register 0xE returns the ROM bank in bits 4:0 and the 3-bit device ID in bits 7:5. The device ID is 7 by default.
- R7: Reading register 0xC returns bit 4 set, bit 6 equal to `dma_sw`, and all other bits 0.
- R8: Reset clears both bank registers to 0 and drops `win_rvalid`.
- R9: `win_rvalid` is high exactly in the cycle after a cycle with `win_rd` high. `win_rdata` is 0 whenever `win_rvalid` is low.
- R10: I/O writes to any offset other than 0xE and 0xF leave both banks unchanged. Reads of offsets other than 0xC and 0xE return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O register write strobe |
| io_addr | input | 4 | I/O register offset |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| dma_sw | input | 1 | DMA-enable switch level |
| win_rd | input | 1 | Window read request |
| win_wr | input | 1 | Window write request |
| win_addr | input | 11 | Window offset |
| win_wdata | input | 8 | Window write data |
| win_rdata | output | 8 | Window read data |
| win_rvalid | output | 1 | Window read data valid |
| sram_re | output | 1 | SRAM read strobe |
| sram_we | output | 1 | SRAM write strobe |
| sram_addr | output | 13 | SRAM byte address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data, one cycle after `sram_re` |

## Verification
The assertions assume the following about the block's inputs:
- A window read and a window write are never requested in the same cycle.
- The external SRAM presents its data in the cycle after `sram_re`.
- `dma_sw` is a static level.

The bench keeps to these assumptions in four ways:
- Every window access is issued from a task that raises exactly one of `win_rd` and `win_wr`.
- Its SRAM model registers its output one edge after the strobe.
- It changes `dma_sw` only between accesses.
- It never overlaps an I/O register write with a window access. The bank in use is therefore always the one written before.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;

   // Which half of the window an access falls into
   typedef enum logic {
      HALF_RAM = 1'b0,
      HALF_ROM = 1'b1
   } win_half_e;

   // Decoded steering of one window access
   typedef struct packed {
      logic sram_rd;
      logic sram_wr;
      logic rom_rd;
      logic dropped;
   } win_steer_t;

   // ROM image variants
   localparam int unsigned ROM_IMG_PATTERN = 0;
   localparam int unsigned ROM_IMG_ECHO    = 1;

endpackage

// File: rtl/bankwin_regs.sv
module bankwin_regs #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned IOADDR_W   = 4,
   parameter int unsigned ROM_BANK_W = 5,
   parameter int unsigned RAM_BANK_W = 3,
   parameter int unsigned DEVID_W    = 3,
   parameter int unsigned DEV_ID     = 7,
   parameter int unsigned ROM_REG    = 14,
   parameter int unsigned RAM_REG    = 15,
   parameter int unsigned CTRL_REG   = 12,
   parameter int unsigned CTRL_FIXED = 4,
   parameter int unsigned CTRL_DMA   = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  io_wr,
   input  logic [IOADDR_W-1:0]   io_addr,
   input  logic [DATA_W-1:0]     io_wdata,
   output logic [DATA_W-1:0]     io_rdata,
   input  logic                  dma_sw,
   output logic [ROM_BANK_W-1:0] rom_bank,
   output logic [RAM_BANK_W-1:0] ram_bank
);

   localparam logic [IOADDR_W-1:0] ROM_SEL  = IOADDR_W'(ROM_REG);
   localparam logic [IOADDR_W-1:0] RAM_SEL  = IOADDR_W'(RAM_REG);
   localparam logic [IOADDR_W-1:0] CTRL_SEL = IOADDR_W'(CTRL_REG);
   localparam logic [DEVID_W-1:0]  ID_VAL   = DEVID_W'(DEV_ID);

   generate
      if (ROM_BANK_W + DEVID_W != DATA_W) begin : g_bad_pack
         $error("bank field and device ID must fill the data byte");
      end
      if (RAM_BANK_W > DATA_W) begin : g_bad_ram
         $error("RAM bank wider than data");
      end
      if (CTRL_FIXED >= DATA_W || CTRL_DMA >= DATA_W || CTRL_FIXED == CTRL_DMA) begin : g_bad_ctrl
         $error("control register bit positions invalid");
      end
      if (ROM_REG == RAM_REG || ROM_REG == CTRL_REG || RAM_REG == CTRL_REG) begin : g_bad_map
         $error("register offsets must differ");
      end
   endgenerate

   logic wr_rom, wr_ram;
   assign wr_rom = io_wr && (io_addr == ROM_SEL);
   assign wr_ram = io_wr && (io_addr == RAM_SEL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rom_bank <= '0;
         ram_bank <= '0;
      end else begin
         if (wr_rom) rom_bank <= io_wdata[ROM_BANK_W-1:0];
         if (wr_ram) ram_bank <= io_wdata[RAM_BANK_W-1:0];
      end
   end

   // Upper write-data bits are not stored by either bank register
   logic unused_wdata;
   assign unused_wdata = ^io_wdata;

   logic [DATA_W-1:0] ctrl_word;
   always_comb begin
      ctrl_word             = '0;
      ctrl_word[CTRL_FIXED] = 1'b1;
      ctrl_word[CTRL_DMA]   = dma_sw;
   end

   always_comb begin
      if (io_addr == ROM_SEL)       io_rdata = {ID_VAL, rom_bank};
      else if (io_addr == CTRL_SEL) io_rdata = ctrl_word;
      else                          io_rdata = '0;
   end

   // R1: ROM bank takes the low bits of the write
   assert_rom_bank_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rom |=> rom_bank == $past(io_wdata[ROM_BANK_W-1:0]));

   // R2: RAM bank takes the low bits of the write
   assert_ram_bank_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ram |=> ram_bank == $past(io_wdata[RAM_BANK_W-1:0]));

   // R10: writes elsewhere keep both banks
   assert_other_write_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr != ROM_SEL && io_addr != RAM_SEL)
         |=> ($stable(rom_bank) && $stable(ram_bank)));

endmodule

// File: rtl/bankwin_decode.sv
module bankwin_decode
   import bankwin_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PAGE_W     = 10,
   parameter int unsigned ROM_BANK_W = 5,
   parameter int unsigned RAM_BANK_W = 3,
   localparam int unsigned WIN_W     = PAGE_W + 1,
   localparam int unsigned SRAM_AW   = RAM_BANK_W + PAGE_W,
   localparam int unsigned ROM_AW    = ROM_BANK_W + PAGE_W
) (
   input  logic                  win_rd,
   input  logic                  win_wr,
   input  logic [WIN_W-1:0]      win_addr,
   input  logic [DATA_W-1:0]     win_wdata,
   input  logic [ROM_BANK_W-1:0] rom_bank,
   input  logic [RAM_BANK_W-1:0] ram_bank,
   output win_half_e             half,
   output win_steer_t            steer,
   output logic [SRAM_AW-1:0]    sram_addr,
   output logic [DATA_W-1:0]     sram_wdata,
   output logic [ROM_AW-1:0]     rom_addr
);

   logic [PAGE_W-1:0] page_off;
   assign page_off = win_addr[PAGE_W-1:0];
   assign half     = win_addr[PAGE_W] ? HALF_ROM : HALF_RAM;

   always_comb begin
      steer = '0;
      unique case (half)
         HALF_RAM: begin
            steer.sram_rd = win_rd;
            steer.sram_wr = win_wr;
         end
         HALF_ROM: begin
            steer.rom_rd  = win_rd;
            steer.dropped = win_wr;
         end
         default: steer = '0;
      endcase
   end

   assign sram_addr  = {ram_bank, page_off};
   assign rom_addr   = {rom_bank, page_off};
   assign sram_wdata = win_wdata;

endmodule

// File: rtl/bankwin_rom.sv
module bankwin_rom
   import bankwin_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PAGE_W    = 10,
   parameter int unsigned ROM_AW    = 15,
   parameter int unsigned IMG_STYLE = ROM_IMG_PATTERN,
   parameter logic [7:0]  IMG_SEED  = 8'h5A
) (
   input  logic              clk,
   input  logic              re,
   input  logic [ROM_AW-1:0] addr,
   output logic [DATA_W-1:0] q
);

   localparam int unsigned BANK_W = ROM_AW - PAGE_W;

   generate
      if (ROM_AW <= PAGE_W) begin : g_bad_aw
         $error("ROM address must exceed page width");
      end
      if (DATA_W < 8) begin : g_bad_dw
         $error("ROM data narrower than a byte");
      end
   endgenerate

   logic [DATA_W-1:0] img;
   logic [BANK_W-1:0] bank_part;
   assign bank_part = addr[ROM_AW-1:PAGE_W];

   generate
      if (IMG_STYLE == ROM_IMG_PATTERN) begin : g_pattern
         // Low address byte mixed with the page number and a seed
         assign img = DATA_W'(addr[7:0])
                    ^ DATA_W'({bank_part, 3'b000})
                    ^ DATA_W'(IMG_SEED);
      end else begin : g_echo
         // Low address byte offset by the seed
         assign img = DATA_W'(addr[7:0] + IMG_SEED);
      end
   endgenerate

   logic unused_addr;
   assign unused_addr = ^addr;

   always_ff @(posedge clk) begin
      if (re) q <= img;
   end

endmodule

// File: rtl/bankwin_mapper.sv
module bankwin_mapper
   import bankwin_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned IOADDR_W   = 4,
   parameter int unsigned PAGE_W     = 10,
   parameter int unsigned ROM_BANK_W = 5,
   parameter int unsigned RAM_BANK_W = 3,
   parameter int unsigned DEVID_W    = 3,
   parameter int unsigned DEV_ID     = 7,
   parameter int unsigned ROM_STYLE  = ROM_IMG_PATTERN,
   parameter logic [7:0]  ROM_SEED   = 8'h5A,
   localparam int unsigned WIN_W     = PAGE_W + 1,
   localparam int unsigned SRAM_AW   = RAM_BANK_W + PAGE_W,
   localparam int unsigned ROM_AW    = ROM_BANK_W + PAGE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                io_wr,
   input  logic [IOADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0]   io_wdata,
   output logic [DATA_W-1:0]   io_rdata,
   input  logic                dma_sw,
   input  logic                win_rd,
   input  logic                win_wr,
   input  logic [WIN_W-1:0]    win_addr,
   input  logic [DATA_W-1:0]   win_wdata,
   output logic [DATA_W-1:0]   win_rdata,
   output logic                win_rvalid,
   output logic                sram_re,
   output logic                sram_we,
   output logic [SRAM_AW-1:0]  sram_addr,
   output logic [DATA_W-1:0]   sram_wdata,
   input  logic [DATA_W-1:0]   sram_rdata
);

   logic [ROM_BANK_W-1:0] rom_bank;
   logic [RAM_BANK_W-1:0] ram_bank;
   win_half_e             half;
   win_steer_t            steer;
   logic [ROM_AW-1:0]     rom_addr;
   logic [DATA_W-1:0]     rom_q;

   bankwin_regs #(
      .DATA_W     (DATA_W),
      .IOADDR_W   (IOADDR_W),
      .ROM_BANK_W (ROM_BANK_W),
      .RAM_BANK_W (RAM_BANK_W),
      .DEVID_W    (DEVID_W),
      .DEV_ID     (DEV_ID)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .io_wr    (io_wr),
      .io_addr  (io_addr),
      .io_wdata (io_wdata),
      .io_rdata (io_rdata),
      .dma_sw   (dma_sw),
      .rom_bank (rom_bank),
      .ram_bank (ram_bank)
   );

   bankwin_decode #(
      .DATA_W     (DATA_W),
      .PAGE_W     (PAGE_W),
      .ROM_BANK_W (ROM_BANK_W),
      .RAM_BANK_W (RAM_BANK_W)
   ) u_decode (
      .win_rd     (win_rd),
      .win_wr     (win_wr),
      .win_addr   (win_addr),
      .win_wdata  (win_wdata),
      .rom_bank   (rom_bank),
      .ram_bank   (ram_bank),
      .half       (half),
      .steer      (steer),
      .sram_addr  (sram_addr),
      .sram_wdata (sram_wdata),
      .rom_addr   (rom_addr)
   );

   bankwin_rom #(
      .DATA_W    (DATA_W),
      .PAGE_W    (PAGE_W),
      .ROM_AW    (ROM_AW),
      .IMG_STYLE (ROM_STYLE),
      .IMG_SEED  (ROM_SEED)
   ) u_rom (
      .clk  (clk),
      .re   (steer.rom_rd),
      .addr (rom_addr),
      .q    (rom_q)
   );

   assign sram_re = steer.sram_rd;
   assign sram_we = steer.sram_wr;

   // Return-path state: data pending, and which half supplies it
   logic      rvalid_q;
   win_half_e half_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         half_q   <= HALF_RAM;
      end else begin
         rvalid_q <= win_rd;
         if (win_rd) half_q <= half;
      end
   end

   assign win_rvalid = rvalid_q;
   assign win_rdata  = !rvalid_q          ? '0 :
                       (half_q == HALF_ROM) ? rom_q : sram_rdata;

   // R3: requests are exclusive
   assert_rd_wr_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(win_rd && win_wr));

   // R3: lower half reads reach the selected SRAM page
   assert_sram_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (win_rd && !win_addr[PAGE_W])
         |-> (sram_re && sram_addr == {ram_bank, win_addr[PAGE_W-1:0]}));

   // R5: upper half writes never strobe the SRAM
   assert_rom_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && win_addr[PAGE_W]) |-> !sram_we);

   // R9: valid one cycle after a read
   assert_rvalid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      win_rd |=> win_rvalid);

   // R9: no valid without a preceding read
   assert_rvalid_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !win_rd |=> !win_rvalid);

   // R9: data is zero while not valid
   assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !win_rvalid |-> win_rdata == '0);

endmodule

// File: tb/bankwin_mapper_tb.sv
module bankwin_mapper_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 1'b0;
   logic [3:0]  io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        dma_sw = 1'b0;
   logic        win_rd = 1'b0;
   logic        win_wr = 1'b0;
   logic [10:0] win_addr = '0;
   logic [7:0]  win_wdata = '0;
   logic [7:0]  win_rdata;
   logic        win_rvalid;
   logic        sram_re, sram_we;
   logic [12:0] sram_addr;
   logic [7:0]  sram_wdata;
   logic [7:0]  sram_rdata = '0;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   bankwin_mapper u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .io_wr      (io_wr),
      .io_addr    (io_addr),
      .io_wdata   (io_wdata),
      .io_rdata   (io_rdata),
      .dma_sw     (dma_sw),
      .win_rd     (win_rd),
      .win_wr     (win_wr),
      .win_addr   (win_addr),
      .win_wdata  (win_wdata),
      .win_rdata  (win_rdata),
      .win_rvalid (win_rvalid),
      .sram_re    (sram_re),
      .sram_we    (sram_we),
      .sram_addr  (sram_addr),
      .sram_wdata (sram_wdata),
      .sram_rdata (sram_rdata)
   );

   // External synchronous SRAM model, sparse
   logic [7:0] sram_mem [int];
   always @(posedge clk) begin
      if (sram_re) sram_rdata <= sram_mem.exists(int'(sram_addr)) ? sram_mem[int'(sram_addr)] : 8'h00;
      if (sram_we) sram_mem[int'(sram_addr)] = sram_wdata;
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic io_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      io_wr = 1'b1; io_addr = a; io_wdata = d;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a;
      #1 d = io_rdata;
   endtask

   task automatic win_write(input logic [10:0] a, input logic [7:0] d);
      @(negedge clk);
      win_wr = 1'b1; win_addr = a; win_wdata = d;
      @(negedge clk);
      win_wr = 1'b0;
   endtask

   task automatic win_read(input string tag, input logic [10:0] a, output logic [7:0] d);
      @(negedge clk);
      win_rd = 1'b1; win_addr = a;
      @(negedge clk);
      chk({tag, " R9 valid"}, 16'(win_rvalid), 16'd1);
      d = win_rdata;
      win_rd = 1'b0;
   endtask

   localparam logic [1:0] OP_IOW = 2'd0, OP_IOR = 2'd1, OP_WW = 2'd2, OP_WR = 2'd3;
   localparam int NV = 24;
   // {req, op, addr, data, expected}
   localparam logic [33:0] VEC [NV] = '{
      {4'd1,  OP_IOW, 12'h00E, 8'h03, 8'h00},  // R1 bank 3
      {4'd1,  OP_IOR, 12'h00E, 8'h00, 8'hE3},  // R1 readback
      {4'd4,  OP_WR,  12'h410, 8'h00, 8'h52},  // R4 page 3
      {4'd1,  OP_IOW, 12'h00E, 8'hFF, 8'h00},  // R1 truncation
      {4'd6,  OP_IOR, 12'h00E, 8'h00, 8'hFF},  // R6 id in 7:5
      {4'd4,  OP_WR,  12'h7FF, 8'h00, 8'h5D},  // R4 top byte
      {4'd2,  OP_IOW, 12'h00F, 8'h0D, 8'h00},  // R2 bank 5
      {4'd3,  OP_WW,  12'h123, 8'hA5, 8'h00},  // R3 write page 5
      {4'd2,  OP_IOW, 12'h00F, 8'h02, 8'h00},  // R2 bank 2
      {4'd3,  OP_WW,  12'h123, 8'h3C, 8'h00},  // R3 write page 2
      {4'd3,  OP_WR,  12'h123, 8'h00, 8'h3C},  // R3 read page 2
      {4'd2,  OP_IOW, 12'h00F, 8'h05, 8'h00},  // R2 back to 5
      {4'd2,  OP_WR,  12'h123, 8'h00, 8'hA5},  // R2 page 5 intact
      {4'd5,  OP_WW,  12'h523, 8'h77, 8'h00},  // R5 ROM-half write
      {4'd5,  OP_WR,  12'h123, 8'h00, 8'hA5},  // R5 SRAM unchanged
      {4'd5,  OP_WR,  12'h523, 8'h00, 8'h81},  // R5 ROM unchanged
      {4'd10, OP_IOW, 12'h00C, 8'hFF, 8'h00},  // R10 write ctrl
      {4'd10, OP_IOW, 12'h003, 8'h1F, 8'h00},  // R10 write other
      {4'd10, OP_IOR, 12'h00E, 8'h00, 8'hFF},  // R10 ROM bank kept
      {4'd7,  OP_IOR, 12'h00C, 8'h00, 8'h10},  // R7 switch off
      {4'd10, OP_IOR, 12'h003, 8'h00, 8'h00},  // R10 other reads 0
      {4'd10, OP_WR,  12'h123, 8'h00, 8'hA5},  // R10 RAM bank kept
      {4'd4,  OP_IOW, 12'h00E, 8'h10, 8'h00},  // R4 bank 16
      {4'd4,  OP_WR,  12'h400, 8'h00, 8'hDA}   // R4 page 16 base
   };

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8: reset state
      chk("R8 rvalid after reset", 16'(win_rvalid), 16'd0);
      chk("R9 rdata idle", 16'(win_rdata), 16'd0);
      io_read(4'hE, d);
      chk("R8 R6 bank0 readback", 16'(d), 16'h00E0);
      win_read("R8", 11'h400, d);
      chk("R8 R4 ROM page 0", 16'(d), 16'h005A);

      for (int i = 0; i < NV; i++) begin
         logic [3:0]  rq;
         logic [1:0]  op;
         logic [11:0] ad;
         logic [7:0]  dt, ex;
         {rq, op, ad, dt, ex} = VEC[i];
         case (op)
            OP_IOW: io_write(ad[3:0], dt);
            OP_WW:  win_write(ad[10:0], dt);
            OP_IOR: begin
               io_read(ad[3:0], d);
               chk($sformatf("R%0d vec %0d", rq, i), 16'(d), 16'(ex));
            end
            default: begin
               win_read($sformatf("R%0d vec %0d", rq, i), ad[10:0], d);
               chk($sformatf("R%0d vec %0d", rq, i), 16'(d), 16'(ex));
            end
         endcase
      end

      // R9: valid drops after the read
      @(negedge clk);
      chk("R9 rvalid low", 16'(win_rvalid), 16'd0);

      // R7: switch on
      dma_sw = 1'b1;
      io_read(4'hC, d);
      chk("R7 switch on", 16'(d), 16'h0050);

      // R3: address mapping seen on the SRAM port
      io_write(4'hF, 8'hF6);
      @(negedge clk);
      win_rd = 1'b1; win_addr = 11'h2AB;
      #1;
      chk("R3 sram_re", 16'(sram_re), 16'd1);
      chk("R3 sram_addr", 16'(sram_addr), 16'h1AAB);
      @(negedge clk);
      win_rd = 1'b0;

      // R5: no SRAM strobe for ROM-half write
      @(negedge clk);
      win_wr = 1'b1; win_addr = 11'h6AB; win_wdata = 8'h11;
      #1;
      chk("R5 sram_we low", 16'(sram_we), 16'd0);
      @(negedge clk);
      win_wr = 1'b0;

      // R3: SRAM strobe for RAM-half write
      @(negedge clk);
      win_wr = 1'b1; win_addr = 11'h0AB; win_wdata = 8'h22;
      #1;
      chk("R3 sram_we high", 16'(sram_we), 16'd1);
      chk("R3 sram_wdata", 16'(sram_wdata), 16'h0022);
      @(negedge clk);
      win_wr = 1'b0;

      // R8: mid-run reset clears banks
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      io_read(4'hE, d);
      chk("R8 ROM bank cleared", 16'(d), 16'h00E0);
      @(negedge clk);
      win_rd = 1'b1; win_addr = 11'h0AB;
      #1;
      chk("R8 RAM bank cleared", 16'(sram_addr), 16'h00AB);
      @(negedge clk);
      win_rd = 1'b0;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule